// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block models a single output cell of a sum-of-products programmable logic array. An already-formed sum term arrives from the AND plane. Static configuration bits then decide three things. The first is whether that term passes straight through, is captured on a rising edge of one of four block clocks, or is held by a transparent latch. The second is whether the captured value loads directly (D) or toggles the stored bit (T). The third is whether the pin sees the true or the inverted value. The cell's own value always returns to the interconnect on a feedback line, so the pin stays free for other use.

The pin is modelled as separate drive, enable and receive lines. The enable comes from one of two block-wide product terms, or it is tied on or off. The pin can therefore be an output, an input, a bidirectional pin or a bus driver. A second storage element can capture the received pin value, as a register or as a latch, on its own input clock. This gives the interconnect a synchronised copy of an external signal.

Everything is sampled on one core clock `clk`. Block clocks, latch gates and the input clock are level inputs, and the cell detects their rising edges itself. Block-wide reset and preset terms act on the stored bit. A test preload can write any value into the stored bit. After power-up reset, clock edges are ignored for a fixed number of core cycles. None of the interfaces carry a stream, so there is no valid/ready handshake and nothing can be back-pressured. Every pin is a plain level.

Top module: `mc_macrocell`

## Requirements
- R1: While `rst_n` is low, and after its release, the stored bit and the captured pin bit are 0. In registered mode this gives `fb_out`=0 and, with input register mode, `pin_fb`=0.
- R2: With `cfg_mode` 2'b00, or the spare code 2'b11, `fb_out` equals `sum_in` in the same cycle.
- R3: With `cfg_mode`=2'b01 and `cfg_ttype`=0, a rising edge of the selected block clock loads `sum_in` into the stored bit, and `fb_out` shows it after that core edge. Without an edge the bit holds.
- R4: With `cfg_mode`=2'b01 and `cfg_ttype`=1, a rising edge inverts the stored bit when `sum_in` is 1 and leaves it unchanged when `sum_in` is 0.
- R5: `cfg_clk_sel` picks block clock index 0..3. Edges on the other three clocks have no effect.
- R6: With `cfg_mode`=2'b10, while the selected clock (used as a gate) is high, `fb_out` follows `sum_in` in the same cycle. While the gate is low, `fb_out` holds the last value.
- R7: `pin_out` equals `fb_out` when `cfg_invert`=0 and its inverse when `cfg_invert`=1.
- R8: `ar_pt` high clears the stored bit at the next core edge, and `ap_pt` high sets it. When both are high, the bit clears. Clocks and mode play no part.
- R9: `preload_en` high writes `preload_val` into the stored bit at the next core edge. It overrides reset, preset and clocks.
- R10: `cfg_oe_sel` encoding: 0 means `pin_oe`=0, 1 means `pin_oe`=1, 2 means `pin_oe`=`oe_pt[0]`, and 3 means `pin_oe`=`oe_pt[1]`.
- R11: Rising edges of block clocks and of `in_clk` are ignored until PWRUP_CYCLES core edges have passed since reset release.
- R12: With `cfg_in_latch`=0, a rising edge of `in_clk` loads `pin_in` into `pin_fb`, which is seen after that core edge. With `cfg_in_latch`=1, `pin_fb` follows `pin_in` while `in_clk` is high and holds while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Active-low power-up reset |
| sum_in | input | 1 | Sum term from the AND plane |
| blk_clk | input | NCLK | Block clock / gate sources |
| ar_pt | input | 1 | Shared reset term |
| ap_pt | input | 1 | Shared preset term |
| oe_pt | input | 2 | Shared output-enable terms |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Test preload value |
| cfg_mode | input | 2 | 00 comb, 01 registered, 10 latch, 11 comb |
| cfg_ttype | input | 1 | 1 selects toggle storage |
| cfg_invert | input | 1 | 1 inverts the pin value |
| cfg_clk_sel | input | SEL_W | Block clock index |
| cfg_oe_sel | input | 2 | Output-enable source |
| cfg_in_latch | input | 1 | Input capture: 0 register, 1 latch |
| in_clk | input | 1 | Input clock / gate |
| pin_in | input | 1 | Value received from the pin |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin drive enable |
| fb_out | output | 1 | Cell feedback to interconnect |
| pin_fb | output | 1 | Captured pin value to interconnect |

## Verification
Combinational and transparent-latch results on `fb_out`, `pin_out`, `pin_oe` and `pin_fb` are due in the same cycle as their input. Edge captures, reset, preset and preload are due after the first core edge at which the inputs are seen. The bench changes inputs on the falling core edge. It compares every output one time unit later against a reference model. That model steps its state only across the rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_REG   = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_SPARE = 2'b11
  } mc_mode_e;

  typedef enum logic [1:0] {
    OE_OFF = 2'b00,
    OE_ON  = 2'b01,
    OE_PT0 = 2'b10,
    OE_PT1 = 2'b11
  } mc_oe_e;
endpackage

// File: rtl/mc_clk_select.sv
module mc_clk_select #(
  parameter int NCLK         = 4,
  parameter int PWRUP_CYCLES = 16,
  localparam int SEL_W = (NCLK > 1) ? $clog2(NCLK) : 1,
  localparam int CNT_W = $clog2(PWRUP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCLK-1:0]  blk_clk,
  input  logic [SEL_W-1:0] sel,
  input  logic             in_clk,
  output logic             cap_edge,
  output logic             gate_lvl,
  output logic             in_edge
);
  logic [NCLK-1:0]  prev_q;
  logic [NCLK-1:0]  rise;
  logic             in_prev_q;
  logic [CNT_W-1:0] wait_cnt;
  logic             ready;

  for (genvar g = 0; g < NCLK; g++) begin : g_rise
    assign rise[g] = blk_clk[g] & ~prev_q[g];
  end

  assign ready    = (wait_cnt == CNT_W'(PWRUP_CYCLES));
  assign cap_edge = ready & rise[sel];
  assign gate_lvl = blk_clk[sel];
  assign in_edge  = ready & in_clk & ~in_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      in_prev_q <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      prev_q    <= blk_clk;
      in_prev_q <= in_clk;
      if (!ready) wait_cnt <= wait_cnt + CNT_W'(1);
    end
  end

  a_r11_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r11_no_early_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt < CNT_W'(PWRUP_CYCLES)) |-> (!cap_edge && !in_edge));
endmodule

// File: rtl/mc_storage.sv
module mc_storage
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mc_mode_e mode,
  input  logic     ttype,
  input  logic     sum_in,
  input  logic     cap_edge,
  input  logic     gate_lvl,
  input  logic     ar,
  input  logic     ap,
  input  logic     pl_en,
  input  logic     pl_val,
  output logic     val_o
);
  logic q;
  logic lat_val;
  logic nxt;

  assign lat_val = gate_lvl ? sum_in : q;

  always_comb begin
    nxt = q;
    case (mode)
      MODE_REG:   if (cap_edge) nxt = ttype ? (q ^ sum_in) : sum_in;
      MODE_LATCH: nxt = lat_val;
      default:    nxt = q;
    endcase
    if (ar)         nxt = 1'b0;
    else if (ap)    nxt = 1'b1;
    if (pl_en)      nxt = pl_val;
  end

  always_comb begin
    case (mode)
      MODE_REG:   val_o = q;
      MODE_LATCH: val_o = lat_val;
      default:    val_o = sum_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end

  a_r9_preload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pl_en |=> (q == $past(pl_val)));
  a_r8_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_en && ar) |=> !q);
  a_r8_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_en && !ar && ap) |=> q);
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_en && !ar && !ap && mode == MODE_REG && ttype && cap_edge)
      |=> (q == ($past(q) ^ $past(sum_in))));
  a_r3_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_en && !ar && !ap && mode == MODE_REG && !cap_edge) |=> $stable(q));
  a_r6_latch_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!pl_en && !ar && !ap && mode == MODE_LATCH && !gate_lvl) |=> $stable(q));
endmodule

// File: rtl/mc_out_cell.sv
module mc_out_cell
  import mc_pkg::*;
#(
  parameter int NOE = 2
) (
  input  logic           val,
  input  logic           invert,
  input  mc_oe_e         oe_sel,
  input  logic [NOE-1:0] oe_pt,
  output logic           pin_out,
  output logic           pin_oe
);
  assign pin_out = val ^ invert;

  always_comb begin
    case (oe_sel)
      OE_OFF:  pin_oe = 1'b0;
      OE_ON:   pin_oe = 1'b1;
      OE_PT0:  pin_oe = oe_pt[0];
      default: pin_oe = oe_pt[NOE-1];
    endcase
  end

  always_comb begin
    a_r7_polarity: assert (pin_out !== val || !invert || $isunknown(val));
  end
endmodule

// File: rtl/mc_in_capture.sv
module mc_in_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic in_edge,
  input  logic in_gate,
  input  logic latch_mode,
  output logic pin_fb
);
  logic in_q;
  logic lat_val;

  assign lat_val = in_gate ? pin_in : in_q;
  assign pin_fb  = latch_mode ? lat_val : in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          in_q <= 1'b0;
    else if (latch_mode) in_q <= lat_val;
    else if (in_edge)    in_q <= pin_in;
  end

  a_r12_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && !in_edge) |=> $stable(in_q));
  a_r12_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && in_edge) |=> (in_q == $past(pin_in)));
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int NCLK         = 4,
  parameter int PWRUP_CYCLES = 16,
  localparam int SEL_W = (NCLK > 1) ? $clog2(NCLK) : 1,
  localparam int NOE   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sum_in,
  input  logic [NCLK-1:0]  blk_clk,
  input  logic             ar_pt,
  input  logic             ap_pt,
  input  logic [NOE-1:0]   oe_pt,
  input  logic             preload_en,
  input  logic             preload_val,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_ttype,
  input  logic             cfg_invert,
  input  logic [SEL_W-1:0] cfg_clk_sel,
  input  logic [1:0]       cfg_oe_sel,
  input  logic             cfg_in_latch,
  input  logic             in_clk,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out,
  output logic             pin_fb
);
  logic cap_edge;
  logic gate_lvl;
  logic in_edge;
  logic cell_val;

  mc_clk_select #(.NCLK(NCLK), .PWRUP_CYCLES(PWRUP_CYCLES)) u_clk (
    .clk(clk), .rst_n(rst_n), .blk_clk(blk_clk), .sel(cfg_clk_sel),
    .in_clk(in_clk), .cap_edge(cap_edge), .gate_lvl(gate_lvl), .in_edge(in_edge)
  );

  mc_storage u_store (
    .clk(clk), .rst_n(rst_n), .mode(mc_mode_e'(cfg_mode)), .ttype(cfg_ttype),
    .sum_in(sum_in), .cap_edge(cap_edge), .gate_lvl(gate_lvl),
    .ar(ar_pt), .ap(ap_pt), .pl_en(preload_en), .pl_val(preload_val),
    .val_o(cell_val)
  );

  mc_out_cell #(.NOE(NOE)) u_out (
    .val(cell_val), .invert(cfg_invert), .oe_sel(mc_oe_e'(cfg_oe_sel)),
    .oe_pt(oe_pt), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  mc_in_capture u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .in_edge(in_edge),
    .in_gate(in_clk), .latch_mode(cfg_in_latch), .pin_fb(pin_fb)
  );

  assign fb_out = cell_val;

  a_r2_comb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b00 || cfg_mode == 2'b11) |-> (fb_out == sum_in));
  a_r5_edge_from_selected: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge |-> blk_clk[cfg_clk_sel]);
endmodule

// File: tb/mc_macrocell_tb.sv
module mc_macrocell_tb;
  localparam int NCLK = 4;
  localparam int PW   = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic sum_in, ar_pt, ap_pt, preload_en, preload_val;
  logic [NCLK-1:0] blk_clk;
  logic [1:0] oe_pt, cfg_mode, cfg_oe_sel, cfg_clk_sel;
  logic cfg_ttype, cfg_invert, cfg_in_latch, in_clk, pin_in;
  logic pin_out, pin_oe, fb_out, pin_fb;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic m_q, m_inq, m_inprev;
  logic [NCLK-1:0] m_prev;
  int m_cnt;

  always #4 clk = ~clk;

  mc_macrocell #(.NCLK(NCLK), .PWRUP_CYCLES(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .blk_clk(blk_clk),
    .ar_pt(ar_pt), .ap_pt(ap_pt), .oe_pt(oe_pt), .preload_en(preload_en),
    .preload_val(preload_val), .cfg_mode(cfg_mode), .cfg_ttype(cfg_ttype),
    .cfg_invert(cfg_invert), .cfg_clk_sel(cfg_clk_sel), .cfg_oe_sel(cfg_oe_sel),
    .cfg_in_latch(cfg_in_latch), .in_clk(in_clk), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .pin_fb(pin_fb)
  );

  task automatic chk(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  function automatic logic exp_fb();
    case (cfg_mode)
      2'b01:   return m_q;
      2'b10:   return blk_clk[cfg_clk_sel] ? sum_in : m_q;
      default: return sum_in;
    endcase
  endfunction

  function automatic logic exp_oe();
    case (cfg_oe_sel)
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return oe_pt[0];
      default: return oe_pt[1];
    endcase
  endfunction

  function automatic logic exp_pinfb();
    if (cfg_in_latch) return in_clk ? pin_in : m_inq;
    return m_inq;
  endfunction

  function automatic string fb_req();
    case (cfg_mode)
      2'b01:   return cfg_ttype ? "R4" : "R3";
      2'b10:   return "R6";
      default: return "R2";
    endcase
  endfunction

  // One cycle: compare settled outputs, advance model over the rising edge.
  task automatic step();
    logic rdy, edg, iedg, nq, ef;
    #1;
    ef = exp_fb();
    chk(fb_req(), fb_out, ef);
    chk("R7", pin_out, ef ^ cfg_invert);
    chk("R10", pin_oe, exp_oe());
    chk("R12", pin_fb, exp_pinfb());
    rdy  = (m_cnt == PW);
    edg  = rdy && blk_clk[cfg_clk_sel] && !m_prev[cfg_clk_sel];
    iedg = rdy && in_clk && !m_inprev;
    nq = m_q;
    if (cfg_mode == 2'b01 && edg) nq = cfg_ttype ? (m_q ^ sum_in) : sum_in;
    if (cfg_mode == 2'b10 && blk_clk[cfg_clk_sel]) nq = sum_in;
    if (ar_pt) nq = 1'b0; else if (ap_pt) nq = 1'b1;
    if (preload_en) nq = preload_val;
    @(posedge clk);
    if (!rst_n) begin
      m_q = 0; m_inq = 0; m_inprev = 0; m_prev = '0; m_cnt = 0;
    end else begin
      m_q = nq;
      if (cfg_in_latch) begin
        if (in_clk) m_inq = pin_in;
      end else if (iedg) m_inq = pin_in;
      m_inprev = in_clk;
      m_prev = blk_clk;
      if (m_cnt < PW) m_cnt++;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic quiet();
    ar_pt = 0; ap_pt = 0; preload_en = 0; preload_val = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    m_q = 0; m_inq = 0; m_inprev = 0; m_prev = '0; m_cnt = 0;
    rst_n = 0; sum_in = 0; blk_clk = '0; oe_pt = 0; in_clk = 0; pin_in = 0;
    quiet();
    cfg_mode = 2'b01; cfg_ttype = 0; cfg_invert = 0; cfg_clk_sel = 0;
    cfg_oe_sel = 2'b01; cfg_in_latch = 0;
    @(negedge clk);
    repeat (3) step();
    // R1: reset state
    #1;
    chk("R1", fb_out, 1'b0);
    chk("R1", pin_fb, 1'b0);
    rst_n = 1;
    // R11: edges ignored during power-up hold-off
    sum_in = 1; pin_in = 1;
    step();
    blk_clk[0] = 1; in_clk = 1; step();
    #1; chk("R11", fb_out, 1'b0); chk("R11", pin_fb, 1'b0);
    blk_clk[0] = 0; in_clk = 0; step();
    blk_clk[0] = 1; in_clk = 1; step();
    #1; chk("R11", fb_out, 1'b0);
    blk_clk[0] = 0; in_clk = 0;
    repeat (PW) step();
    // R3: D capture after hold-off
    blk_clk[0] = 1; in_clk = 1; step();
    #1; chk("R3", fb_out, 1'b1); chk("R12", pin_fb, 1'b1);
    // R5: unselected clock ignored
    blk_clk = '0; in_clk = 0; sum_in = 0; step();
    blk_clk[2] = 1; step();
    #1; chk("R5", fb_out, 1'b1);
    blk_clk = '0; step();
    // R8: reset beats preset
    ar_pt = 1; ap_pt = 1; step();
    #1; chk("R8", fb_out, 1'b0);
    ar_pt = 0; step();
    #1; chk("R8", fb_out, 1'b1);
    // R9: preload beats reset
    ap_pt = 0; ar_pt = 1; preload_en = 1; preload_val = 1; step();
    #1; chk("R9", fb_out, 1'b1);
    quiet();
    // R4: toggle
    cfg_ttype = 1; sum_in = 1; blk_clk[0] = 1; step();
    #1; chk("R4", fb_out, 1'b0);
    blk_clk[0] = 0; step();
    // Random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 250 == 0) begin
        cfg_mode = 2'($urandom); cfg_ttype = 1'($urandom);
        cfg_invert = 1'($urandom); cfg_clk_sel = 2'($urandom);
        cfg_oe_sel = 2'($urandom); cfg_in_latch = 1'($urandom);
      end
      sum_in = 1'($urandom);
      for (int k = 0; k < NCLK; k++)
        if ($urandom % 3 == 0) blk_clk[k] = ~blk_clk[k];
      if ($urandom % 3 == 0) in_clk = ~in_clk;
      pin_in = 1'($urandom);
      oe_pt = 2'($urandom);
      ar_pt = ($urandom % 16 == 0);
      ap_pt = ($urandom % 16 == 0);
      preload_en = ($urandom % 32 == 0);
      preload_val = 1'($urandom);
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule